// File: doc/BRIEF.md
# CPU Clock Ratio Control Register

This block holds the software-visible setting that chooses the ratio between the processor clock and its reference. Software writes one word holding an enable flag and a two-bit ratio code. The block checks that the word is legal, applies the new ratio to its `ratio_o` output after a fixed settling period, and shows a busy flag while that period runs. A write that breaks the encoding rules latches a fault output and freezes the block until reset. The clock generator itself is outside the block. A counter of `SETTLE_CYCLES` clocks stands in for the lock time of the generator.

Writes are single-cycle strobes: `wr_en` is sampled on each rising edge. There is no back-pressure pin. A write that arrives while the block is busy or faulted is dropped. `rd_data` always shows the register contents, one cycle after the edge that changed them. When the parameter `HAS_MULT` is 0, the block is built without the feature. In that variant `rd_data` is always zero and every write is dropped.

Top module: `cpu_ratio_ctl`

## Requirements
- R1: After reset, `rd_data` reads 0x0001, `ratio_o` is 0 (1x), and `busy_o` and `fault_o` are both 0.
- R2: `ratio_o` encodes 0 = 1x, 1 = 2x and 2 = 3x, and it never takes the value 3. Legal writes of 0x0001, 0x0003 and 0x0005 select 1x, 2x and 3x.
- R3: A write with bit 0 set and bits 2:1 = 3 selects 3x. For example, 0x0007 behaves like 0x0005.
- R4: Write bits 15:3 have no effect. For example, 0xFF0B selects 2x and 0x001F selects 3x.
- R5: A write with bit 0 clear is illegal, whatever bits 2:1 hold. On the next edge it sets `fault_o`, and it leaves both `ratio_o` and `rd_data` unchanged.
- R6: `fault_o` stays set until reset. While it is set, every write is ignored.
- R7: A legal write whose ratio differs from the current `ratio_o` raises `busy_o` on the next edge for exactly `SETTLE_CYCLES` cycles. `ratio_o` takes the new value on the same edge where `busy_o` falls.
- R8: Any write that arrives while `busy_o` is 1 is ignored, whether it is legal or illegal.
- R9: A legal write whose ratio equals the current ratio updates `rd_data` and does not raise `busy_o`.
- R10: In `rd_data`, bit 0 is the stored enable, bits 2:1 are the stored code as written, bit 15 is `busy_o`, and every other bit reads 0.
- R11: With `HAS_MULT` = 0, `rd_data` reads 0 after any write, `ratio_o` stays 0, and `busy_o` and `fault_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 16 | Word to write |
| rd_data | output | 16 | Register read value |
| ratio_o | output | 2 | Applied clock ratio (0 = 1x, 1 = 2x, 2 = 3x) |
| busy_o | output | 1 | Ratio change still settling |
| fault_o | output | 1 | Sticky fault after an illegal write |

## Verification
The bench drives four kinds of write pattern:
- Canonical words for each ratio separate the three ratio decodes from one another.
- Aliased words, meaning code 3 and words with high bits set, show whether the upper bits and the fourth code are truly ignored.
- A legal write to the current ratio followed by a change of ratio shows whether busy is raised only when the ratio actually changes.
- Writes repeated during busy, and an illegal word followed by a legal one, show whether the guard that drops writes holds in both the busy state and the fault state.

A second instance built without the feature receives the same writes, so any leak of register state into that variant shows up.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;

  typedef enum logic [1:0] {
    RATIO_1X = 2'd0,
    RATIO_2X = 2'd1,
    RATIO_3X = 2'd2
  } ratio_e;

  localparam int EN_BIT   = 0;
  localparam int CODE_LSB = 1;
  localparam int CODE_W   = 2;
  localparam int CFG_W    = 1 + CODE_W;

  // Map a ratio code to the applied ratio; code 3 aliases onto 3x.
  function automatic ratio_e code_to_ratio(input logic [CODE_W-1:0] code);
    case (code)
      2'd0:    code_to_ratio = RATIO_1X;
      2'd1:    code_to_ratio = RATIO_2X;
      default: code_to_ratio = RATIO_3X;
    endcase
  endfunction

endpackage

// File: rtl/clkmul_decode.sv
module clkmul_decode
  import clkmul_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              legal_o,
  output logic [CODE_W-1:0] code_o,
  output ratio_e            target_o
);

  // Only a set enable makes a word legal; a clear enable is rejected
  // even with a zero code.
  always_comb begin
    legal_o  = cfg_i[EN_BIT];
    code_o   = cfg_i[CODE_LSB +: CODE_W];
    target_o = code_to_ratio(code_o);
  end

endmodule

// File: rtl/clkmul_settle.sv
module clkmul_settle #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  AST_SETTLE_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o) else $error("restart while settling"); // R8

  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD) else $error("settle counter out of range"); // R7

endmodule

// File: rtl/clkmul_core.sv
module clkmul_core
  import clkmul_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_cfg_i,
  output logic [CFG_W-1:0] cfg_o,
  output ratio_e           ratio_o,
  output logic             busy_o,
  output logic             fault_o
);

  logic              legal;
  logic [CODE_W-1:0] code;
  ratio_e            target;
  logic              accept;
  logic              start;
  logic              done;

  logic              en_q;
  logic [CODE_W-1:0] code_q;
  ratio_e            ratio_q;
  ratio_e            pend_q;
  logic              fault_q;

  clkmul_decode u_decode (
    .cfg_i   (wr_cfg_i),
    .legal_o (legal),
    .code_o  (code),
    .target_o(target)
  );

  clkmul_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start),
    .busy_o (busy_o),
    .done_o (done)
  );

  assign accept = wr_en_i && !busy_o && !fault_q;
  assign start  = accept && legal && (target != ratio_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      code_q  <= '0;
      ratio_q <= RATIO_1X;
      pend_q  <= RATIO_1X;
      fault_q <= 1'b0;
    end else begin
      if (done) begin
        ratio_q <= pend_q;
      end
      if (accept) begin
        if (legal) begin
          en_q   <= 1'b1;
          code_q <= code;
          if (start) begin
            pend_q <= target;
          end
        end else begin
          fault_q <= 1'b1;
        end
      end
    end
  end

  assign cfg_o   = {code_q, en_q};
  assign ratio_o = ratio_q;
  assign fault_o = fault_q;

  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q != 2'd3) else $error("ratio code 3 on output"); // R2

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q) else $error("fault cleared without reset"); // R6

  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !busy_o) |=> ($stable(ratio_q) && $stable(cfg_o))) else $error("state moved while faulted"); // R6

  AST_ILLEGAL_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_cfg_i[EN_BIT] && !busy_o) |=> fault_q) else $error("illegal write not faulted"); // R5

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || $stable(ratio_q))) else $error("ratio moved mid-settle"); // R7

  AST_BUSY_DROPS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done) |=> $stable(cfg_o)) else $error("write accepted while busy"); // R8

endmodule

// File: rtl/cpu_ratio_ctl.sv
module cpu_ratio_ctl
  import clkmul_pkg::*;
#(
  parameter bit HAS_MULT      = 1'b1,
  parameter int SETTLE_CYCLES = 16,
  parameter int DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        ratio_o,
  output logic              busy_o,
  output logic              fault_o
);

  localparam int BUSY_BIT = DATA_W - 1;
  localparam int GAP_W    = BUSY_BIT - CFG_W;

  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data[DATA_W-1:CFG_W];

  generate
    if (HAS_MULT) begin : g_mult
      logic [CFG_W-1:0] cfg;
      ratio_e           ratio;
      logic             busy;
      logic             fault;

      clkmul_core #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .wr_cfg_i(wr_data[CFG_W-1:0]),
        .cfg_o   (cfg),
        .ratio_o (ratio),
        .busy_o  (busy),
        .fault_o (fault)
      );

      assign rd_data = {busy, {GAP_W{1'b0}}, cfg};
      assign ratio_o = ratio;
      assign busy_o  = busy;
      assign fault_o = fault;
    end else begin : g_none
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ wr_en ^ (^wr_data[CFG_W-1:0]);
      assign rd_data = '0;
      assign ratio_o = RATIO_1X;
      assign busy_o  = 1'b0;
      assign fault_o = 1'b0;
    end
  endgenerate

endmodule

// File: tb/test_cpu_ratio_ctl.sv
module test_cpu_ratio_ctl;

  localparam int S = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, rd_off;
  logic [1:0]  ratio_o, ratio_off;
  logic        busy_o, busy_off, fault_o, fault_off;

  int n_checks = 0;
  int n_fail = 0;
  bit started = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model state
  int m_en, m_code, m_ratio, m_pend, m_cnt, m_fault;

  always #2.5 clk = ~clk;

  cpu_ratio_ctl #(.SETTLE_CYCLES(S)) i_cpu_ratio_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ratio_o(ratio_o), .busy_o(busy_o), .fault_o(fault_o)
  );

  cpu_ratio_ctl #(.HAS_MULT(1'b0), .SETTLE_CYCLES(S)) i_cpu_ratio_ctl_off (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_off), .ratio_o(ratio_off), .busy_o(busy_off), .fault_o(fault_off)
  );

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_en = 1; m_code = 0; m_ratio = 0; m_pend = 0; m_cnt = 0; m_fault = 0;
    end else begin
      automatic bit busy_old = (m_cnt != 0);
      if (m_cnt == 1) m_ratio = m_pend;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (wr_en && !busy_old && m_fault == 0) begin
        if (wr_data[0]) begin
          automatic int tgt;
          m_en = 1;
          m_code = int'(wr_data[2:1]);
          tgt = (m_code == 0) ? 0 : (m_code == 1) ? 1 : 2;
          if (tgt != m_ratio) begin
            m_pend = tgt;
            m_cnt = S;
          end
        end else begin
          m_fault = 1;
        end
      end
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s/%s %s: actual 0x%0h expected 0x%0h at %0t", phase, req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      automatic int exp_rd = ((m_cnt != 0) ? 32'h8000 : 0) | (m_code << 1) | m_en;
      cmp("R10", "rd_data", int'(rd_data), exp_rd);
      cmp("R2", "ratio_o", int'(ratio_o), m_ratio);
      cmp("R7", "busy_o", int'(busy_o), (m_cnt != 0) ? 1 : 0);
      cmp("R5", "fault_o", int'(fault_o), m_fault);
      cmp("R11", "rd_data off", int'(rd_off), 0);
      cmp("R11", "ratio off", int'(ratio_off), 0);
      cmp("R11", "busy/fault off", int'({busy_off, fault_off}), 0);
    end
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    phase = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(3);
    phase = "R2";
    wr(16'h0003); idle(S + 3);
    wr(16'h0005); idle(S + 3);
    wr(16'h0001); idle(S + 3);
    phase = "R3";
    wr(16'h0007); idle(S + 3);
    phase = "R9";
    wr(16'h000F); idle(4);
    wr(16'h0005); idle(4);
    phase = "R4";
    wr(16'hFF0B); idle(S + 3);
    wr(16'h001F); idle(S + 3);
    wr(16'hFFFF); idle(4);
    phase = "R8";
    wr(16'h0001);
    for (int i = 0; i < 5; i++) wr(16'h0003);
    wr(16'h0000);
    idle(S + 3);
    phase = "R5";
    wr(16'h0004); idle(3);
    phase = "R6";
    wr(16'h0003); idle(3);
    wr(16'h0005); idle(S + 2);
    phase = "R1";
    do_reset(); idle(3);
    phase = "R5";
    wr(16'h0000); idle(3);
    do_reset();
    phase = "R11";
    wr(16'h0005); idle(S + 3);
    wr(16'h0006); idle(3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule